// File: doc/BRIEF.md
# Prioritised Interrupt Entry Controller

This block decides, once per clock, whether the processor core must leave its current instruction stream and enter an exception handler. It watches three sources: a fast interrupt request line, a normal interrupt request line (both level-sensitive and owned by peripherals) and a software-interrupt request raised by the instruction decoder. The two mask bits in the current status word decide which hardware sources may be taken. The fast request always wins over the normal one, and both hardware requests win over the software one.

When an entry is taken, the block raises a one-cycle pulse. Together with that pulse it presents four values: the handler's vector address, the status word the core must adopt, the old status word and the return address. The last two must be written into the target mode's saved-status and link registers. The pulse also serves as the register-file write strobe, and the target mode output acts as the mode override that steers those writes into the right bank. The core is expected to load the new status word on the edge that follows the pulse. The controller blocks a second entry in that cycle, so the still-asserted level request cannot be taken twice.

Top module: `irq_entry_ctrl`

## Requirements
- R1: While reset is asserted (active low), `take_o` is 0 and every data output (`vector_o`, `new_status_o`, `save_status_o`, `link_o`, `tgt_mode_o`) is 0.
- R2: A fast request taken when status bit 6 is 0 gives, one clock edge later, `take_o`=1, `vector_o`=0x0000_001C and `tgt_mode_o`=5'b10001. `new_status_o` then has bits 6 and 7 set.
- R3: A normal request taken when status bit 7 is 0 gives `take_o`=1, `vector_o`=0x0000_0018 and `tgt_mode_o`=5'b10010 one edge later. `new_status_o` has bit 7 set and bit 6 copied from the old status.
- R4: A software request is never masked. It gives `take_o`=1, `vector_o`=0x0000_0008 and `tgt_mode_o`=5'b10011 one edge later, with bit 7 of `new_status_o` set and bit 6 copied.
- R5: When several eligible requests share a cycle, the fast request is taken over the normal one, and either hardware request is taken over the software one.
- R6: A fast request with status bit 6 set, or a normal request with status bit 7 set, is ignored: with no other eligible request, `take_o` stays 0 and no output changes.
- R7: On an entry, `save_status_o` equals the status word and `link_o` equals the return address presented at the sampling edge. Every bit of `new_status_o` above bit 4 other than bits 6 and 7 equals the old status bit. Bits 4..0 hold the target mode.
- R8: `take_o` is a single-cycle pulse. Requests present in the cycle right after an entry are not taken.
- R9: While `take_o` is 0, all data outputs hold the values of the last entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| fiq_req_i | input | 1 | Fast interrupt request, level-sensitive |
| irq_req_i | input | 1 | Normal interrupt request, level-sensitive |
| swi_req_i | input | 1 | Software interrupt request from decode |
| status_i | input | DW | Current status word (bit 7 normal mask, bit 6 fast mask, bits 4..0 mode) |
| ret_addr_i | input | DW | Return address to save on entry |
| take_o | output | 1 | Entry pulse, also the register-file write strobe |
| vector_o | output | DW | Handler vector address |
| new_status_o | output | DW | Status word to adopt on entry |
| save_status_o | output | DW | Old status word for the saved-status register |
| link_o | output | DW | Return address for the link register |
| tgt_mode_o | output | 5 | Target mode, used as the register-bank override |

## Verification
Every result of this block is due exactly one rising edge after the inputs that caused it: the pulse, vector, new status, saved status, link value and target mode are all registered at the sampling edge. The bench drives each cycle's inputs at a falling edge and compares all outputs at the next falling edge. A reference model in the bench carries forward the previous expected pulse, so the blocked cycle after each entry and the hold behaviour are predicted rather than sampled around. Directed cases cover each source alone, the masks, all priority pairings and back-to-back requests. A seeded random phase mixes request and mask patterns.

// File: rtl/irq_entry_pkg.sv
// Shared definitions for the interrupt entry controller: the source
// encoding chosen by the arbiter and the processor mode codes.
package irq_entry_pkg;

    localparam int unsigned MODE_W = 5;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_SWI  = 2'd1,
        SRC_IRQ  = 2'd2,
        SRC_FIQ  = 2'd3
    } entry_src_e;

    localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
    localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
    localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;

endpackage

// File: rtl/irq_entry_arb.sv
// Priority arbiter. Picks the source to enter this cycle.
// Order: fast > normal > software. Hardware sources are gated by their
// mask bits; the software source is never masked. block_i suppresses
// every source (used for the cycle after an entry).
module irq_entry_arb
    import irq_entry_pkg::*;
(
    input  logic       fiq_req_i,
    input  logic       irq_req_i,
    input  logic       swi_req_i,
    input  logic       fiq_dis_i,
    input  logic       irq_dis_i,
    input  logic       block_i,
    output entry_src_e src_o
);

    logic fiq_ok;
    logic irq_ok;

    // Eligibility of each hardware source after masking.
    always_comb begin
        fiq_ok = fiq_req_i && !fiq_dis_i;
        irq_ok = irq_req_i && !irq_dis_i;
    end

    // Fixed-priority selection.
    always_comb begin
        if (block_i)        src_o = SRC_NONE;
        else if (fiq_ok)    src_o = SRC_FIQ;
        else if (irq_ok)    src_o = SRC_IRQ;
        else if (swi_req_i) src_o = SRC_SWI;
        else                src_o = SRC_NONE;
    end

endmodule

// File: rtl/irq_entry_fmt.sv
// Entry formatter. For the chosen source it computes the vector address,
// the target mode and the status word the core adopts on entry.
// Assumes the mode field occupies bits MODE_W-1..0 and the mask bits lie
// above it. Output is meaningless when src_i is SRC_NONE.
module irq_entry_fmt
    import irq_entry_pkg::*;
#(
    parameter int unsigned   DW          = 32,
    parameter logic [DW-1:0] VEC_BASE    = '0,
    parameter int unsigned   FIQ_DIS_BIT = 6,
    parameter int unsigned   IRQ_DIS_BIT = 7
) (
    input  entry_src_e        src_i,
    input  logic [DW-1:0]     status_i,
    output logic [DW-1:0]     vector_o,
    output logic [DW-1:0]     new_status_o,
    output logic [MODE_W-1:0] mode_o
);

    localparam logic [DW-1:0] OFF_SWI = DW'(8);
    localparam logic [DW-1:0] OFF_IRQ = DW'(24);
    localparam logic [DW-1:0] OFF_FIQ = DW'(28);

    logic [DW-1:0] offset;
    logic          is_fiq;

    // Vector offset and mode per source.
    always_comb begin
        unique case (src_i)
            SRC_FIQ: begin offset = OFF_FIQ; mode_o = MODE_FIQ; end
            SRC_IRQ: begin offset = OFF_IRQ; mode_o = MODE_IRQ; end
            default: begin offset = OFF_SWI; mode_o = MODE_SVC; end
        endcase
        is_fiq   = (src_i == SRC_FIQ);
        vector_o = VEC_BASE + offset;
    end

    // Per-bit construction of the new status word.
    for (genvar b = 0; b < DW; b++) begin : g_stat
        if (b < MODE_W) begin : g_mode
            assign new_status_o[b] = mode_o[b];
        end else if (b == IRQ_DIS_BIT) begin : g_imask
            assign new_status_o[b] = 1'b1;
        end else if (b == FIQ_DIS_BIT) begin : g_fmask
            assign new_status_o[b] = status_i[b] | is_fiq;
        end else begin : g_keep
            assign new_status_o[b] = status_i[b];
        end
    end

endmodule

// File: rtl/irq_entry_seq.sv
// Entry register stage. Captures the entry outputs on the edge where an
// entry is taken and holds them otherwise. The pulse is one cycle wide
// because the arbiter is blocked while take_o is high.
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic [DW-1:0]     vector_i,
    input  logic [DW-1:0]     new_status_i,
    input  logic [DW-1:0]     status_i,
    input  logic [DW-1:0]     ret_addr_i,
    input  logic [MODE_W-1:0] mode_i,
    output logic              take_o,
    output logic [DW-1:0]     vector_o,
    output logic [DW-1:0]     new_status_o,
    output logic [DW-1:0]     save_status_o,
    output logic [DW-1:0]     link_o,
    output logic [MODE_W-1:0] tgt_mode_o
);

    // Entry pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) take_o <= 1'b0;
        else        take_o <= take_i;
    end

    // Entry data registers, loaded only on a taken entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vector_o      <= '0;
            new_status_o  <= '0;
            save_status_o <= '0;
            link_o        <= '0;
            tgt_mode_o    <= '0;
        end else if (take_i) begin
            vector_o      <= vector_i;
            new_status_o  <= new_status_i;
            save_status_o <= status_i;
            link_o        <= ret_addr_i;
            tgt_mode_o    <= mode_i;
        end
    end

endmodule

// File: rtl/irq_entry_ctrl.sv
// Top of the interrupt entry controller. Samples the request lines and
// the status word on each rising edge, selects the highest-priority
// eligible source and presents a registered entry record with a
// one-cycle take pulse. Assumes the core loads new_status_o on the edge
// after take_o, so the cycle after an entry is blocked.
module irq_entry_ctrl
    import irq_entry_pkg::*;
#(
    parameter int unsigned   DW          = 32,
    parameter logic [DW-1:0] VEC_BASE    = '0,
    parameter int unsigned   FIQ_DIS_BIT = 6,
    parameter int unsigned   IRQ_DIS_BIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fiq_req_i,
    input  logic              irq_req_i,
    input  logic              swi_req_i,
    input  logic [DW-1:0]     status_i,
    input  logic [DW-1:0]     ret_addr_i,
    output logic              take_o,
    output logic [DW-1:0]     vector_o,
    output logic [DW-1:0]     new_status_o,
    output logic [DW-1:0]     save_status_o,
    output logic [DW-1:0]     link_o,
    output logic [MODE_W-1:0] tgt_mode_o
);

    entry_src_e        src;
    logic [DW-1:0]     vec_c;
    logic [DW-1:0]     nstat_c;
    logic [MODE_W-1:0] mode_c;
    logic              take_c;

    irq_entry_arb u_arb (
        .fiq_req_i (fiq_req_i),
        .irq_req_i (irq_req_i),
        .swi_req_i (swi_req_i),
        .fiq_dis_i (status_i[FIQ_DIS_BIT]),
        .irq_dis_i (status_i[IRQ_DIS_BIT]),
        .block_i   (take_o),
        .src_o     (src)
    );

    irq_entry_fmt #(
        .DW          (DW),
        .VEC_BASE    (VEC_BASE),
        .FIQ_DIS_BIT (FIQ_DIS_BIT),
        .IRQ_DIS_BIT (IRQ_DIS_BIT)
    ) u_fmt (
        .src_i        (src),
        .status_i     (status_i),
        .vector_o     (vec_c),
        .new_status_o (nstat_c),
        .mode_o       (mode_c)
    );

    // An entry is taken whenever the arbiter picked a source.
    always_comb take_c = (src != SRC_NONE);

    irq_entry_seq #(
        .DW (DW)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .take_i        (take_c),
        .vector_i      (vec_c),
        .new_status_i  (nstat_c),
        .status_i      (status_i),
        .ret_addr_i    (ret_addr_i),
        .mode_i        (mode_c),
        .take_o        (take_o),
        .vector_o      (vector_o),
        .new_status_o  (new_status_o),
        .save_status_o (save_status_o),
        .link_o        (link_o),
        .tgt_mode_o    (tgt_mode_o)
    );

endmodule

// File: rtl/irq_entry_ctrl_chk.sv
// Property checker for irq_entry_ctrl, observing ports only. Attached to
// every instance of the top module by the bind at the end of this file.
module irq_entry_ctrl_chk
    import irq_entry_pkg::*;
#(
    parameter int unsigned   DW          = 32,
    parameter logic [DW-1:0] VEC_BASE    = '0,
    parameter int unsigned   FIQ_DIS_BIT = 6,
    parameter int unsigned   IRQ_DIS_BIT = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fiq_req_i,
    input logic              irq_req_i,
    input logic              swi_req_i,
    input logic [DW-1:0]     status_i,
    input logic [DW-1:0]     ret_addr_i,
    input logic              take_o,
    input logic [DW-1:0]     vector_o,
    input logic [DW-1:0]     new_status_o,
    input logic [DW-1:0]     save_status_o,
    input logic [DW-1:0]     link_o,
    input logic [MODE_W-1:0] tgt_mode_o
);

    localparam logic [DW-1:0] V_SWI = VEC_BASE + DW'(8);
    localparam logic [DW-1:0] V_IRQ = VEC_BASE + DW'(24);
    localparam logic [DW-1:0] V_FIQ = VEC_BASE + DW'(28);

    logic fiq_ok;
    logic irq_ok;
    assign fiq_ok = fiq_req_i && !status_i[FIQ_DIS_BIT];
    assign irq_ok = irq_req_i && !status_i[IRQ_DIS_BIT];

    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);

    p_fiq_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_o && fiq_ok) |=> (take_o && tgt_mode_o == MODE_FIQ && vector_o == V_FIQ
                                 && new_status_o[FIQ_DIS_BIT] && new_status_o[IRQ_DIS_BIT]));

    p_irq_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_o && irq_ok && !fiq_ok) |=> (take_o && tgt_mode_o == MODE_IRQ
                                            && vector_o == V_IRQ && new_status_o[IRQ_DIS_BIT]));

    p_swi_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_o && swi_req_i && !fiq_ok && !irq_ok) |=> (take_o && tgt_mode_o == MODE_SVC
                                                          && vector_o == V_SWI));

    p_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!swi_req_i && !fiq_ok && !irq_ok) |=> !take_o);

    p_save_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_o && (swi_req_i || fiq_ok || irq_ok)) |=>
            (save_status_o == $past(status_i) && link_o == $past(ret_addr_i)));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> ($stable(vector_o) && $stable(new_status_o) && $stable(save_status_o)
                     && $stable(link_o) && $stable(tgt_mode_o)));

endmodule

bind irq_entry_ctrl irq_entry_ctrl_chk #(
    .DW          (DW),
    .VEC_BASE    (VEC_BASE),
    .FIQ_DIS_BIT (FIQ_DIS_BIT),
    .IRQ_DIS_BIT (IRQ_DIS_BIT)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fiq_req_i     (fiq_req_i),
    .irq_req_i     (irq_req_i),
    .swi_req_i     (swi_req_i),
    .status_i      (status_i),
    .ret_addr_i    (ret_addr_i),
    .take_o        (take_o),
    .vector_o      (vector_o),
    .new_status_o  (new_status_o),
    .save_status_o (save_status_o),
    .link_o        (link_o),
    .tgt_mode_o    (tgt_mode_o)
);

// File: tb/irq_entry_ctrl_tb.sv
// Self-checking bench for irq_entry_ctrl: directed corners, then seeded
// random cycles, compared against a reference model written from the
// requirements.
module irq_entry_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fiq_r = 1'b0;
    logic        irq_r = 1'b0;
    logic        swi_r = 1'b0;
    logic [31:0] stat_r = '0;
    logic [31:0] ret_r = '0;
    logic        take_w;
    logic [31:0] vec_w, nstat_w, save_w, link_w;
    logic [4:0]  mode_w;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state
    logic        m_take = 1'b0;
    logic [31:0] m_vec = '0, m_nstat = '0, m_save = '0, m_link = '0;
    logic [4:0]  m_mode = '0;

    always #4 clk = ~clk;

    irq_entry_ctrl dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .fiq_req_i     (fiq_r),
        .irq_req_i     (irq_r),
        .swi_req_i     (swi_r),
        .status_i      (stat_r),
        .ret_addr_i    (ret_r),
        .take_o        (take_w),
        .vector_o      (vec_w),
        .new_status_o  (nstat_w),
        .save_status_o (save_w),
        .link_o        (link_w),
        .tgt_mode_o    (mode_w)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Source code: 0 none, 1 software, 2 normal, 3 fast.
    function automatic int pick(input logic f, input logic i, input logic w, input logic [31:0] s, input logic blk);
        if (blk) return 0;
        if (f && !s[6]) return 3;
        if (i && !s[7]) return 2;
        if (w) return 1;
        return 0;
    endfunction

    function automatic logic [31:0] vec_of(input int src);
        return (src == 3) ? 32'h1C : (src == 2) ? 32'h18 : 32'h08;
    endfunction

    function automatic logic [4:0] mode_of(input int src);
        return (src == 3) ? 5'b10001 : (src == 2) ? 5'b10010 : 5'b10011;
    endfunction

    function automatic logic [31:0] stat_of(input int src, input logic [31:0] s);
        logic [31:0] n = s;
        n[4:0] = mode_of(src);
        n[7] = 1'b1;
        if (src == 3) n[6] = 1'b1;
        return n;
    endfunction

    // One cycle: drive at a falling edge, compare at the next falling edge.
    task automatic run(input logic f, input logic i, input logic w, input logic [31:0] s, input logic [31:0] pc);
        int src, nreq;
        string tag;
        fiq_r = f; irq_r = i; swi_r = w; stat_r = s; ret_r = pc;
        src  = pick(f, i, w, s, m_take);
        nreq = int'(f && !s[6]) + int'(i && !s[7]) + int'(w);
        if (m_take && nreq > 0)        tag = "R8";
        else if (src == 0 && (f || i)) tag = "R6";
        else if (src == 0)             tag = "R9";
        else if (nreq > 1)             tag = "R5";
        else if (src == 3)             tag = "R2";
        else if (src == 2)             tag = "R3";
        else                           tag = "R4";
        if (src != 0) begin
            m_vec = vec_of(src); m_mode = mode_of(src); m_nstat = stat_of(src, s);
            m_save = s; m_link = pc;
        end
        m_take = (src != 0);
        @(posedge clk);
        @(negedge clk);
        chk(tag, "take", {31'd0, take_w}, {31'd0, m_take});
        chk(tag, "vector", vec_w, m_vec);
        chk(tag, "mode", {27'd0, mode_w}, {27'd0, m_mode});
        chk(tag, "new_status", nstat_w, m_nstat);
        chk("R7", "save_status", save_w, m_save);
        chk("R7", "link", link_w, m_link);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        fiq_r = 1'b1; irq_r = 1'b1; swi_r = 1'b1; stat_r = '0; ret_r = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset holds everything at zero despite requests.
        chk("R1", "take", {31'd0, take_w}, 32'd0);
        chk("R1", "vector", vec_w, 32'd0);
        chk("R1", "new_status", nstat_w, 32'd0);
        chk("R1", "save_status", save_w, 32'd0);
        chk("R1", "link", link_w, 32'd0);
        chk("R1", "mode", {27'd0, mode_w}, 32'd0);
        fiq_r = 1'b0; irq_r = 1'b0; swi_r = 1'b0;
        rst_n = 1'b1;

        run(1'b1, 1'b0, 1'b0, 32'h0000_0013, 32'h0000_0100); // R2 fast alone
        run(1'b0, 1'b0, 1'b0, 32'h0000_00D1, 32'h0);         // R9 idle hold
        run(1'b0, 1'b1, 1'b0, 32'h0000_0013, 32'h0000_0200); // R3 normal alone
        run(1'b0, 1'b0, 1'b0, 32'h0000_0092, 32'h0);
        run(1'b0, 1'b0, 1'b1, 32'h0000_00D0, 32'h0000_0300); // R4 software under masks
        run(1'b0, 1'b0, 1'b0, 32'h0000_00D3, 32'h0);
        run(1'b1, 1'b1, 1'b1, 32'h0000_0010, 32'h0000_0400); // R5 fast wins
        run(1'b1, 1'b1, 1'b1, 32'h0000_0010, 32'h0000_0404); // R8 blocked
        run(1'b0, 1'b1, 1'b1, 32'h0000_0010, 32'h0000_0408); // R5 normal over software
        run(1'b0, 1'b0, 1'b0, 32'h0000_0010, 32'h0);
        run(1'b1, 1'b1, 1'b0, 32'h0000_0050, 32'h0000_0500); // R6 fast masked, normal taken
        run(1'b0, 1'b0, 1'b0, 32'h0000_0050, 32'h0);
        run(1'b1, 1'b1, 1'b0, 32'h0000_00C0, 32'h0000_0600); // R6 both masked
        run(1'b1, 1'b0, 1'b0, 32'h0000_0040, 32'h0000_0604); // R6 fast masked alone
        run(1'b0, 1'b1, 1'b0, 32'hA5A5_A52F, 32'h0000_0700); // R7 upper bits kept

        // Seeded random phase.
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] s = $urandom;
            run(($urandom % 4) == 0, ($urandom % 3) == 0, ($urandom % 6) == 0, s, $urandom);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule